// File: doc/BRIEF.md
# Flash Query and Identifier Read Formatter

This block produces the read word a host sees when a parallel flash bank is in identifier mode or in query mode. The bank is made of several identical devices placed side by side on the data bus, and each device may run narrower than its native width. From the byte offset on the bus, the access size and three static width settings, the block works out which table entry or identifier each device would return. It then copies that answer into every device lane, and packs one bank-wide answer per bank slice into the bus word.

A command decoder outside this block chooses between identifier mode and query mode and raises a request strobe. The formatted word appears one clock later together with a valid strobe. The query table is a fixed ROM held inside the block. The two identifier values are static inputs.

Top module: `cfi_resp_fmt`

## Requirements
- R1: While rst_ni is low, and at the first sample after reset is released, rvalid_o is 0 and rdata_o is 0.
- R2: The table index is off_i shifted right by log2(BANK_W) + log2(MAX_DEV_W) - log2(DEV_W). When DEV_W equals MAX_DEV_W, query mode (qry_mode_i = 1) returns the table byte at that index zero-extended to DEV_W bytes. The table holds 0x52 entries: 0x51, 0x52 and 0x59 at indices 0x10, 0x11 and 0x12, and (7*i + 3) mod 256 at every other index i.
- R3: A query at index 0x10, 0x11 or 0x12 returns the ASCII characters Q, R, Y in each device lane.
- R4: A query whose index is 0x52 or more returns zero.
- R5: Within a bank slice, every one of the BANK_W/DEV_W device lanes (8*DEV_W bits each, lane 0 lowest) carries the same device answer.
- R6: When DEV_W is 1 and MAX_DEV_W is larger than 1, a query returns the table byte in every byte lane, not a zero-padded value.
- R7: When DEV_W differs from MAX_DEV_W and DEV_W is not 1, every query returns zero.
- R8: In identifier mode (qry_mode_i = 0), only bits 7:0 of the index are decoded. Value 0 selects mfr_id_i, value 1 selects dev_id_i, and any other value returns zero. The selected value is cut or zero-extended to 8*DEV_W bits.
- R9: width_i selects the access size: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. The word holds max(1, size/BANK_W) slices. Slice k is computed from off_i + k*BANK_W and placed at bits [8*BANK_W*k +: 8*BANK_W]. All bits above the last slice are zero.
- R10: rvalid_o is req_i delayed by one clock, and rdata_o carries the answer to that request. rdata_o holds its value while req_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request strobe |
| qry_mode_i | input | 1 | 1 selects query mode, 0 selects identifier mode |
| off_i | input | ADDR_W | Byte offset on the bus |
| width_i | input | 2 | Access size code |
| mfr_id_i | input | 16 | Manufacturer identifier |
| dev_id_i | input | 16 | Device identifier |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 8*BUS_W | Formatted read word |

## Verification
Four copies of the block are driven with the same stimulus, each with a different width setting:
- a native x16 pair on a 32-bit bus;
- x16 parts run in x8 mode;
- a mismatched setting that is neither native nor x8;
- a byte-wide bank.

The offset sweep runs past the end of the table and wraps the identifier decode. Each point is tried with all three access sizes in both modes.

This separates index scaling errors (shift off by one bit), padding against repetition, the zero answer for a mismatch, the slice-offset stepping that only a byte-wide bank shows under wide accesses, and the masking of the high identifier index bits. Idle cycles after the sweep show that the output word holds between requests.

// File: rtl/cfi_fmt_pkg.sv
package cfi_fmt_pkg;

  localparam int unsigned QRY_DEPTH = 82;  // 0x52 table entries

  typedef enum logic {
    MODE_ID  = 1'b0,
    MODE_QRY = 1'b1
  } rd_mode_e;

  function automatic logic [7:0] qry_entry(input logic [6:0] i);
    logic [7:0] v;
    case (i)
      7'h10:   v = 8'h51;
      7'h11:   v = 8'h52;
      7'h12:   v = 8'h59;
      default: v = {1'b0, i} * 8'd7 + 8'd3;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cfi_qry_rom.sv
module cfi_qry_rom
  import cfi_fmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] idx_i,
  output logic [7:0]        byte_o
);

  logic hit;

  assign hit    = idx_i < ADDR_W'(QRY_DEPTH);
  assign byte_o = hit ? qry_entry(idx_i[6:0]) : 8'h00;

endmodule

// File: rtl/cfi_slice_fmt.sv
module cfi_slice_fmt
  import cfi_fmt_pkg::*;
#(
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 2,
  parameter int unsigned MAX_DEV_W = 2,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic [ADDR_W-1:0]   off_i,
  input  logic                qry_mode_i,
  input  logic [15:0]         mfr_id_i,
  input  logic [15:0]         dev_id_i,
  output logic [ADDR_W-1:0]   idx_o,
  output logic [8*BANK_W-1:0] data_o
);

  localparam int unsigned SHIFT = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);
  localparam int unsigned NLANE = BANK_W / DEV_W;
  localparam int unsigned DW    = 8 * DEV_W;
  localparam bit          X8    = (DEV_W == 1) && (MAX_DEV_W > 1);
  localparam bit          BAD   = (DEV_W != MAX_DEV_W) && !X8;

  logic [7:0]    tbl_byte;
  logic [DW-1:0] q_dev;
  logic [DW-1:0] id_dev;
  logic [DW-1:0] dev_resp;
  logic [15:0]   id_val;

  assign idx_o = off_i >> SHIFT;

  cfi_qry_rom #(.ADDR_W(ADDR_W)) u_rom (
    .idx_i  (idx_o),
    .byte_o (tbl_byte)
  );

  // query answer of one device
  if (X8) begin : g_x8
    logic [8*MAX_DEV_W-1:0] rep;
    assign rep   = {MAX_DEV_W{tbl_byte}};
    assign q_dev = rep[DW-1:0];
  end else if (BAD) begin : g_bad
    assign q_dev = '0;
  end else begin : g_native
    always_comb begin
      q_dev      = '0;
      q_dev[7:0] = tbl_byte;
    end
  end

  // identifier answer of one device; high index bits ignored
  always_comb begin
    case (idx_o[7:0])
      8'd0:    id_val = mfr_id_i;
      8'd1:    id_val = dev_id_i;
      default: id_val = 16'h0000;
    endcase
    id_dev = '0;
    for (int b = 0; b < DEV_W && b < 2; b++) id_dev[8*b+:8] = id_val[8*b+:8];
  end

  assign dev_resp = (qry_mode_i == MODE_QRY) ? q_dev : id_dev;
  assign data_o   = {NLANE{dev_resp}};

endmodule

// File: rtl/cfi_resp_fmt.sv
module cfi_resp_fmt
  import cfi_fmt_pkg::*;
#(
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned DEV_W     = 2,
  parameter int unsigned MAX_DEV_W = 2,
  parameter int unsigned BUS_W     = 4,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                qry_mode_i,
  input  logic [ADDR_W-1:0]   off_i,
  input  logic [1:0]          width_i,
  input  logic [15:0]         mfr_id_i,
  input  logic [15:0]         dev_id_i,
  output logic                rvalid_o,
  output logic [8*BUS_W-1:0]  rdata_o
);

  localparam int unsigned DATA_W = 8 * BUS_W;
  localparam int unsigned SW     = 8 * BANK_W;
  localparam int unsigned NSLICE = BUS_W / BANK_W;
  localparam int unsigned NLANE  = BANK_W / DEV_W;
  localparam int unsigned DW     = 8 * DEV_W;
  localparam bit          BAD    = (DEV_W != MAX_DEV_W) && !((DEV_W == 1) && (MAX_DEV_W > 1));

  if (DEV_W > MAX_DEV_W || DEV_W > BANK_W || BANK_W > BUS_W || MAX_DEV_W > 4 || BUS_W > 4)
  begin : g_cfg_err
    $error("cfi_resp_fmt: unsupported width parameters");
  end

  logic [2:0]        acc_bytes;
  logic [DATA_W-1:0] word;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    case (width_i)
      2'd0:    acc_bytes = 3'd1;
      2'd1:    acc_bytes = 3'd2;
      default: acc_bytes = 3'd4;
    endcase
  end

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    logic [ADDR_W-1:0] s_off;
    logic [ADDR_W-1:0] s_idx;
    logic [SW-1:0]     s_data;
    logic              s_act;

    assign s_off = off_i + ADDR_W'(k * BANK_W);
    assign s_act = (k == 0) || (32'(k * BANK_W) < 32'(acc_bytes));

    cfi_slice_fmt #(
      .BANK_W    (BANK_W),
      .DEV_W     (DEV_W),
      .MAX_DEV_W (MAX_DEV_W),
      .ADDR_W    (ADDR_W)
    ) u_slice (
      .off_i      (s_off),
      .qry_mode_i (qry_mode_i),
      .mfr_id_i   (mfr_id_i),
      .dev_id_i   (dev_id_i),
      .idx_o      (s_idx),
      .data_o     (s_data)
    );

    assign word[k*SW+:SW] = s_act ? s_data : '0;

    assert_oob_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (qry_mode_i && s_idx >= ADDR_W'(QRY_DEPTH)) |-> (s_data == '0));

    assert_id_other_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!qry_mode_i && s_idx[7:0] > 8'd1) |-> (s_data == '0));

    if (BAD) begin : g_bad_chk
      assert_mismatch_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        qry_mode_i |-> (s_data == '0));
    end

    for (genvar l = 1; l < NLANE; l++) begin : g_lane_chk
      assert_lane_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_data[l*DW+:DW] == s_data[DW-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i;
      if (req_i) rdata_q <= word;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  assert_valid_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rvalid_o && $stable(rdata_o)));

  if (BANK_W < BUS_W) begin : g_upper_chk
    assert_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && width_i == 2'd0) |=> (rdata_o[DATA_W-1:SW] == '0));
  end

endmodule

// File: tb/cfi_resp_fmt_test.sv
`timescale 1ns/1ps
module cfi_resp_fmt_test;

  localparam int NI = 4;
  localparam logic [15:0] MFR = 16'hA7C3;
  localparam logic [15:0] DID = 16'h5E19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        qmode = 1'b0;
  logic [15:0] off = '0;
  logic [1:0]  wsel = '0;
  logic        rv [NI];
  logic [31:0] rd [NI];

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] q_exp [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  // config per instance: bank, dev, max
  cfi_resp_fmt #(.BANK_W(4), .DEV_W(2), .MAX_DEV_W(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .qry_mode_i(qmode), .off_i(off),
    .width_i(wsel), .mfr_id_i(MFR), .dev_id_i(DID), .rvalid_o(rv[0]), .rdata_o(rd[0]));
  cfi_resp_fmt #(.BANK_W(4), .DEV_W(1), .MAX_DEV_W(2)) uut_x8 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .qry_mode_i(qmode), .off_i(off),
    .width_i(wsel), .mfr_id_i(MFR), .dev_id_i(DID), .rvalid_o(rv[1]), .rdata_o(rd[1]));
  cfi_resp_fmt #(.BANK_W(4), .DEV_W(2), .MAX_DEV_W(4)) uut_mis (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .qry_mode_i(qmode), .off_i(off),
    .width_i(wsel), .mfr_id_i(MFR), .dev_id_i(DID), .rvalid_o(rv[2]), .rdata_o(rd[2]));
  cfi_resp_fmt #(.BANK_W(1), .DEV_W(1), .MAX_DEV_W(1)) uut_b1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .qry_mode_i(qmode), .off_i(off),
    .width_i(wsel), .mfr_id_i(MFR), .dev_id_i(DID), .rvalid_o(rv[3]), .rdata_o(rd[3]));

  function automatic int lg2(input int v);
    return (v == 4) ? 2 : (v == 2) ? 1 : 0;
  endfunction

  function automatic int tbl(input int i);
    if (i == 16) return 'h51;
    if (i == 17) return 'h52;
    if (i == 18) return 'h59;
    return (7 * i + 3) % 256;
  endfunction

  function automatic longint ref_slice(input int bw, input int dw, input int mw,
                                       input bit q, input int o);
    int     idx;
    longint d;
    longint s;
    idx = o >> (lg2(bw) + lg2(mw) - lg2(dw));
    if (q) begin
      if (idx >= 82) d = 0;
      else if (dw == mw || dw == 1) d = tbl(idx);
      else d = 0;
    end else begin
      int i8;
      i8 = idx & 255;
      d  = (i8 == 0) ? longint'(MFR) : (i8 == 1) ? longint'(DID) : 0;
      d  = d & ((longint'(1) << (8 * dw)) - 1);
    end
    s = 0;
    for (int l = 0; l < bw / dw; l++) s = s | (d << (8 * dw * l));
    return s;
  endfunction

  function automatic logic [31:0] ref_word(input int bw, input int dw, input int mw,
                                           input bit q, input int o, input int ws);
    int     acc;
    int     ns;
    longint r;
    acc = (ws == 0) ? 1 : (ws == 1) ? 2 : 4;
    ns  = acc / bw;
    if (ns < 1) ns = 1;
    r = 0;
    for (int k = 0; k < ns; k++)
      r = r | (ref_slice(bw, dw, mw, q, (o + k * bw) & 16'hFFFF) << (8 * bw * k));
    return r[31:0];
  endfunction

  function automatic string tag_for(input int inst, input bit q, input int o);
    case (inst)
      0:       return q ? (((o >> 2) >= 82) ? "R4" : "R2") : "R5";
      1:       return q ? "R6" : "R8";
      2:       return q ? "R7" : "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one request and queues expectations for all instances
  task automatic drive(input bit q, input int o, input int ws, input string ovr);
    @(negedge clk);
    req   = 1'b1;
    qmode = q;
    off   = 16'(o);
    wsel  = 2'(ws);
    q_exp.push_back(ref_word(4, 2, 2, q, o, ws));
    q_exp.push_back(ref_word(4, 1, 2, q, o, ws));
    q_exp.push_back(ref_word(4, 2, 4, q, o, ws));
    q_exp.push_back(ref_word(1, 1, 1, q, o, ws));
    for (int i = 0; i < NI; i++) q_tag.push_back(ovr != "" ? ovr : tag_for(i, q, o));
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && rv[0]) begin
      for (int i = 0; i < NI; i++) begin
        if (q_exp.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R10: actual=result without request expected=no result");
        end else begin
          logic [31:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check(t, rd[i], e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check("R1", {31'b0, rv[i]}, 32'd0);
      check("R1", rd[i], 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'b0, rv[0]}, 32'd0);
    check("R1", rd[0], 32'd0);

    // QRY signature, explicit
    drive(1'b1, 'h40, 2, "R3");
    drive(1'b1, 'h44, 2, "R3");
    drive(1'b1, 'h48, 2, "R3");
    drive(1'b1, 'h40, 3, "R9");

    for (int m = 0; m < 2; m++)
      for (int ws = 0; ws < 3; ws++)
        for (int o = 0; o < 768; o++)
          drive(m[0], o, ws, "");

    // identifier decode ignores high index bits
    drive(1'b0, 256 << 3, 2, "");
    drive(1'b0, (257 << 3), 2, "");
    drive(1'b0, 256 << 2, 2, "");
    drive(1'b0, 1024, 0, "");

    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    held = rd[0];
    qmode = 1'b1;
    off   = 16'h0044;
    repeat (3) @(negedge clk);
    check("R10", {31'b0, rv[0]}, 32'd0);
    check("R10", rd[0], held);
    check("R10", 32'(q_exp.size()), 32'd0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule